// File: doc/BRIEF.md
# Oscillator Trim Bisection Controller

This block searches for the trim code that pulls a slow oscillator into a wanted frequency band. A search begins on a start pulse. At that moment the block takes in a trim range and an inclusive band of acceptable meter counts. It then bisects the range. For each candidate code it drives the code onto the trim output and issues one start pulse to an external frequency meter. It waits for the meter's done handshake and compares the returned count against the band.

If a candidate lands in the band, the search ends with that code. If the bisection collapses without a hit, the controller measures both remaining bounds. It keeps the one whose count lies closer to the lower band edge, and a tie goes to the upper bound. The result is presented on its own output and announced with a single-cycle done pulse.

Top module: `osc_trim_search`

## Requirements
- R1: A start pulse is accepted only while idle; it captures the range limits and the band limits, and later changes of those inputs or further start pulses during a search have no effect on that search.
- R2: Each trial drives its trim code before the meter start pulse. Exactly one one-cycle meter start is issued per measurement. The next step waits for the meter's done handshake.
- R3: The trial code is the floor of (lower bound + upper bound) / 2. A count inside [band low, band high], both edges inclusive, ends the search with that code as the result.
- R4: A count above band high makes the trial code the new upper bound. Any other out-of-band count, including zero, makes it the new lower bound.
- R5: When the trial code would equal the lower bound, or the lower bound is not below the upper bound (including a range given reversed), bisection stops without measuring.
- R6: After bisection stops without a hit, the lower bound is measured first and then the upper bound. Each count is scored by its absolute distance to band low. The lower bound wins only on a strictly smaller distance; on a tie the upper bound wins.
- R7: Done is high for exactly one cycle per search, and the result output only changes in that cycle. It holds until the next search completes.
- R8: Out of reset the trim code, the result, done and meter start are all zero.
- R9: The trim code stays unchanged from the meter start until the meter's done is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (taken when idle) |
| codeMin | input | 6 | Lowest trim code of the range |
| codeMax | input | 6 | Highest trim code of the range |
| bandLo | input | 12 | Lowest acceptable meter count |
| bandHi | input | 12 | Highest acceptable meter count |
| measCount | input | 12 | Count returned by the meter |
| measDone | input | 1 | Meter result valid, one cycle |
| trimCode | output | 6 | Trim code applied to the oscillator |
| measStart | output | 1 | One-cycle request for a measurement |
| resultCode | output | 6 | Chosen trim code |
| done | output | 1 | One-cycle search-complete pulse |

## Verification
The meter start appears two cycles after an accepted start pulse: one cycle to capture the limits and one to compute and drive the trial code. After each done handshake that sends the search back to bisection, the next meter start comes two cycles later. Done rises in the cycle after the edge that samples the deciding meter done, and the result is valid from that same cycle. The bench samples every output on the falling edge and polls for done rather than counting a fixed delay. It counts meter start pulses to check how many measurements each search made. The cycle after done, and a few cycles later, it checks that done has dropped and that the result has held.

// File: rtl/trim_pkg.sv
package trim_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CALC,
    ST_ISSUE,
    ST_WAIT,
    ST_FIN
  } trimState_t;

  typedef enum logic [1:0] {
    PH_SEARCH,
    PH_EDGE_L,
    PH_EDGE_R
  } trimPhase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBounds;
    logic driveMid;
    logic driveLeft;
    logic driveRight;
    logic moveLeft;
    logic moveRight;
    logic saveDiff;
    logic takeMid;
    logic takeFallback;
  } trimStrobes_t;

  // conditions from datapath to control
  typedef struct packed {
    logic noSplit;
    logic inBand;
    logic aboveHigh;
    logic preferLeft;
  } trimStatus_t;

endpackage

// File: rtl/trim_dp.sv
module trim_dp
  import trim_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  trimStrobes_t      stb,
  input  logic [CODE_W-1:0] codeMin,
  input  logic [CODE_W-1:0] codeMax,
  input  logic [CNT_W-1:0]  bandLo,
  input  logic [CNT_W-1:0]  bandHi,
  input  logic [CNT_W-1:0]  measCount,
  output trimStatus_t       status,
  output logic [CODE_W-1:0] trimCode,
  output logic [CODE_W-1:0] resultCode
);

  localparam int SUM_W = CODE_W + 1;

  logic [CODE_W-1:0] leftQ, rightQ, midQ, trimQ, resQ;
  logic [CNT_W-1:0]  loQ, hiQ, diffLQ;
  logic [SUM_W-1:0]  sumW;
  logic [CODE_W-1:0] midNow;
  logic [CNT_W-1:0]  distNow;

  assign sumW   = {1'b0, leftQ} + {1'b0, rightQ};
  assign midNow = sumW[SUM_W-1:1];

  assign distNow = (measCount > loQ) ? (measCount - loQ) : (loQ - measCount);

  assign status.noSplit    = (leftQ >= rightQ) || (midNow == leftQ);
  assign status.inBand     = (measCount >= loQ) && (measCount <= hiQ);
  assign status.aboveHigh  = (measCount > hiQ);
  assign status.preferLeft = (diffLQ < distNow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leftQ  <= '0;
      rightQ <= '0;
      midQ   <= '0;
      trimQ  <= '0;
      resQ   <= '0;
      loQ    <= '0;
      hiQ    <= '0;
      diffLQ <= '0;
    end else begin
      if (stb.loadBounds) begin
        leftQ  <= codeMin;
        rightQ <= codeMax;
        loQ    <= bandLo;
        hiQ    <= bandHi;
      end
      if (stb.driveMid) begin
        midQ  <= midNow;
        trimQ <= midNow;
      end
      if (stb.driveLeft)  trimQ  <= leftQ;
      if (stb.driveRight) trimQ  <= rightQ;
      if (stb.moveLeft)   leftQ  <= midQ;
      if (stb.moveRight)  rightQ <= midQ;
      if (stb.saveDiff)   diffLQ <= distNow;
      if (stb.takeMid)    resQ   <= midQ;
      if (stb.takeFallback) resQ <= status.preferLeft ? leftQ : rightQ;
    end
  end

  assign trimCode   = trimQ;
  assign resultCode = resQ;

endmodule

// File: rtl/trim_ctrl.sv
module trim_ctrl
  import trim_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         measDone,
  input  trimStatus_t  status,
  output trimStrobes_t stb,
  output logic         measStart,
  output logic         done
);

  trimState_t stateQ, stateNext;
  trimPhase_t phaseQ, phaseNext;

  always_comb begin
    stb       = '0;
    stateNext = stateQ;
    phaseNext = phaseQ;
    case (stateQ)
      ST_IDLE: begin
        if (start) begin
          stb.loadBounds = 1'b1;
          phaseNext      = PH_SEARCH;
          stateNext      = ST_CALC;
        end
      end
      ST_CALC: begin
        if (status.noSplit) begin
          stb.driveLeft = 1'b1;
          phaseNext     = PH_EDGE_L;
        end else begin
          stb.driveMid = 1'b1;
        end
        stateNext = ST_ISSUE;
      end
      ST_ISSUE: stateNext = ST_WAIT;
      ST_WAIT: begin
        if (measDone) begin
          case (phaseQ)
            PH_SEARCH: begin
              if (status.inBand) begin
                stb.takeMid = 1'b1;
                stateNext   = ST_FIN;
              end else if (status.aboveHigh) begin
                stb.moveRight = 1'b1;
                stateNext     = ST_CALC;
              end else begin
                stb.moveLeft = 1'b1;
                stateNext    = ST_CALC;
              end
            end
            PH_EDGE_L: begin
              stb.saveDiff   = 1'b1;
              stb.driveRight = 1'b1;
              phaseNext      = PH_EDGE_R;
              stateNext      = ST_ISSUE;
            end
            default: begin
              stb.takeFallback = 1'b1;
              stateNext        = ST_FIN;
            end
          endcase
        end
      end
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      phaseQ <= PH_SEARCH;
    end else begin
      stateQ <= stateNext;
      phaseQ <= phaseNext;
    end
  end

  assign measStart = (stateQ == ST_ISSUE);
  assign done      = (stateQ == ST_FIN);

endmodule

// File: rtl/osc_trim_search.sv
module osc_trim_search
  import trim_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CODE_W-1:0] codeMin,
  input  logic [CODE_W-1:0] codeMax,
  input  logic [CNT_W-1:0]  bandLo,
  input  logic [CNT_W-1:0]  bandHi,
  input  logic [CNT_W-1:0]  measCount,
  input  logic              measDone,
  output logic [CODE_W-1:0] trimCode,
  output logic              measStart,
  output logic [CODE_W-1:0] resultCode,
  output logic              done
);

  trimStrobes_t stb;
  trimStatus_t  status;

  trim_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .measDone  (measDone),
    .status    (status),
    .stb       (stb),
    .measStart (measStart),
    .done      (done)
  );

  trim_dp #(
    .CODE_W (CODE_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .codeMin    (codeMin),
    .codeMax    (codeMax),
    .bandLo     (bandLo),
    .bandHi     (bandHi),
    .measCount  (measCount),
    .status     (status),
    .trimCode   (trimCode),
    .resultCode (resultCode)
  );

endmodule

// File: rtl/trim_search_chk.sv
module trim_search_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              measStart,
  input logic              measDone,
  input logic [CODE_W-1:0] trimCode,
  input logic [CODE_W-1:0] resultCode,
  input logic              done
);

  // a measurement is outstanding between meter start and meter done
  logic pendQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pendQ <= 1'b0;
    else if (measStart) pendQ <= 1'b1;
    else if (measDone)  pendQ <= 1'b0;
  end

  p_single_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    measStart |=> !measStart);

  p_wait_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    measStart |-> !pendQ);

  p_trim_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    pendQ |-> $stable(trimCode));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(resultCode) |-> done);

endmodule

bind osc_trim_search trim_search_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .measStart  (measStart),
  .measDone   (measDone),
  .trimCode   (trimCode),
  .resultCode (resultCode),
  .done       (done)
);

// File: tb/sim_osc_trim_search.sv
module sim_osc_trim_search;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  codeMin = '0, codeMax = '0;
  logic [11:0] bandLo = '0, bandHi = '0;
  logic [11:0] measCount = '0;
  logic        measDone = 1'b0;
  logic [5:0]  trimCode, resultCode;
  logic        measStart, done;

  int checks = 0;
  int errors = 0;
  int nMeas = 0;
  int mLat = 1;
  int mSlope = 10;

  always #2 clk = ~clk;

  osc_trim_search u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .codeMin(codeMin), .codeMax(codeMax), .bandLo(bandLo), .bandHi(bandHi),
    .measCount(measCount), .measDone(measDone),
    .trimCode(trimCode), .measStart(measStart),
    .resultCode(resultCode), .done(done)
  );

  // meter model: count = slope * code, reported mLat cycles after start
  initial begin
    bit pend = 0;
    int cd = 0;
    logic [11:0] val = '0;
    forever begin
      @(negedge clk);
      measDone = 1'b0;
      if (pend) begin
        if (cd == 0) begin
          measDone = 1'b1; measCount = val; pend = 0;
        end else cd--;
      end
      if (measStart) begin
        pend = 1; cd = mLat - 1;
        val = 12'(mSlope * int'(trimCode));
        nMeas++;
      end
    end
  end

  typedef struct packed {
    logic [5:0]  mn;
    logic [5:0]  mx;
    logic [11:0] lo;
    logic [11:0] hi;
    logic [7:0]  slope;
    logic [2:0]  lat;
    logic [5:0]  expCode;
    logic [3:0]  expMeas;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{6'd0,  6'd63, 12'd300,  12'd320,  8'd10, 3'd1, 6'd31, 4'd1}, // R3 first hit
    '{6'd0,  6'd63, 12'd400,  12'd405,  8'd10, 3'd2, 6'd40, 4'd6}, // R3 R4 low edge hit
    '{6'd0,  6'd63, 12'd403,  12'd405,  8'd10, 3'd3, 6'd40, 4'd8}, // R6 left closer
    '{6'd0,  6'd63, 12'd405,  12'd406,  8'd10, 3'd1, 6'd41, 4'd8}, // R6 tie to right
    '{6'd0,  6'd63, 12'd1000, 12'd1010, 8'd10, 3'd2, 6'd63, 4'd8}, // R4 all low
    '{6'd10, 6'd11, 12'd108,  12'd200,  8'd10, 3'd1, 6'd11, 4'd2}, // R5 no split
    '{6'd10, 6'd11, 12'd100,  12'd100,  8'd10, 3'd4, 6'd10, 4'd2}, // R6 left strictly
    '{6'd20, 6'd20, 12'd0,    12'd0,    8'd10, 3'd1, 6'd20, 4'd2}, // R5 equal bounds
    '{6'd30, 6'd5,  12'd100,  12'd110,  8'd10, 3'd2, 6'd5,  4'd2}, // R5 reversed
    '{6'd0,  6'd63, 12'd5,    12'd10,   8'd0,  3'd1, 6'd63, 4'd8}, // R4 zero counts
    '{6'd0,  6'd63, 12'd0,    12'd5,    8'd10, 3'd3, 6'd0,  4'd7}, // R4 all high
    '{6'd0,  6'd63, 12'd395,  12'd400,  8'd10, 3'd5, 6'd40, 4'd6}  // R3 high edge hit
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (done !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
    check({req, " done seen"}, int'(done === 1'b1), 1);
  endtask

  task automatic runVec(input vec_t v);
    codeMin = v.mn; codeMax = v.mx; bandLo = v.lo; bandHi = v.hi;
    mSlope = int'(v.slope); mLat = int'(v.lat);
    nMeas = 0;
    pulseStart();
    waitDone("R3");
    check("R3/R4/R5/R6 result", int'(resultCode), int'(v.expCode));
    check("R2 measurement count", nMeas, int'(v.expMeas));
    @(negedge clk);
    check("R7 done one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    check("R7 result held", int'(resultCode), int'(v.expCode));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8 reset state
    check("R8 trimCode", int'(trimCode), 0);
    check("R8 resultCode", int'(resultCode), 0);
    check("R8 done", int'(done), 0);
    check("R8 measStart", int'(measStart), 0);

    for (int i = 0; i < NV; i++) runVec(VECS[i]);

    // R1: second start and input changes during a search are ignored
    codeMin = 6'd0; codeMax = 6'd63; bandLo = 12'd400; bandHi = 12'd405;
    mSlope = 10; mLat = 3; nMeas = 0;
    pulseStart();
    repeat (4) @(negedge clk);
    codeMin = 6'd10; codeMax = 6'd11; bandLo = 12'd300; bandHi = 12'd320;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    waitDone("R1");
    check("R1 busy start ignored result", int'(resultCode), 40);
    check("R1 busy start ignored count", nMeas, 6);
    @(negedge clk);
    check("R1 single done", int'(done), 0);

    // R1: start accepted again once idle, with the new limits
    codeMin = 6'd0; codeMax = 6'd63; nMeas = 0;
    pulseStart();
    waitDone("R1");
    check("R1 restart result", int'(resultCode), 31);
    check("R1 restart count", nMeas, 1);

    // R2: meter start two cycles after the accepted start, code already driven
    codeMin = 6'd0; codeMax = 6'd63; bandLo = 12'd300; bandHi = 12'd320;
    mLat = 2;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R2 no early start", int'(measStart), 0);
    @(negedge clk);
    check("R2 meter start timing", int'(measStart), 1);
    check("R2 code before start", int'(trimCode), 31);
    @(negedge clk);
    check("R2 start one cycle", int'(measStart), 0);
    waitDone("R2");
    check("R9 trim unchanged result", int'(resultCode), 31);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule